// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns a 64-bit instruction fetch address into a 44-bit physical address in one registered stage. A request is handled on the cycle in which `req_valid` is high. The translator settles the path for the request: firmware bypass, physical pass-through, a superpage window that only the kernel may use, or a lookup in an external translation buffer. It then checks the mode against that entry's execute permission mask. The physical address, an uncacheable flag and a two-bit fault code appear on the next cycle.

The translation buffer is outside the block. It is reached through a lookup port that carries the virtual page number and the address space number out, and that must return hit, page frame and execute mask in the same cycle. The page table base value is an input. When an access violation or a miss is found, the block saves the fetch address and a formatted table pointer in two fault registers. The fault handler reads these registers. Pages are 8 KB, virtual addresses are 43 bits wide, and the mode is a 2-bit value in which kernel is 0.

Top module: `ifetch_xlate`

## Requirements
- R1: When bit 0 of the fetch address is set, the result is the fetch address with bits 1:0 cleared and cut to 44 bits. The fault code is 0 and the uncacheable flag is 0. The physical flag, the mode and the lookup port have no effect.
- R2: With bit 0 clear and `req_phys` high, the physical address is the fetch address. A lookup hit or miss does not change the result.
- R3: In any other case, a fetch address whose bits 63:42 are not all equal gives fault code 1 (access violation).
- R4: When the superpage enable is high and address bits 42:41 equal binary 10, kernel mode bypasses the lookup. The address is cut to 44 bits. If bit 39 or bit 40 is then set, bits 43:40 are forced to ones. Otherwise bits 43:40 are cleared.
- R5: A superpage access in any mode other than 0 gives fault code 1.
- R6: With the superpage enable low, an address in the superpage window goes through the lookup like any other address.
- R7: A lookup miss gives fault code 2. The external buffer decides hit or miss from the page number and the address space number.
- R8: On a hit, the physical address is the page frame shifted left by 13 bits, joined with address bits 12:2 and two zero bits.
- R9: On a hit whose execute mask bit at index `req_mode` is clear, the result is fault code 1.
- R10: On the physical path, any set bit in fetch address bits 63:44 gives fault code 3 (machine check).
- R11: A result with fault code 0 that is not a firmware fetch has the uncacheable flag set exactly when physical address bit 39 or bit 40 is set.
- R12: On fault code 1 or 2, `fault_tag` takes the fetch address. `fault_vaform` takes the page table base ORed with address bits 42:13 shifted left by 3. Fault codes 0 and 3 leave both registers unchanged.
- R13: A response appears with `rsp_valid` exactly one cycle after a request. Reset clears every output. A cycle with no request produces no response and changes no fault register.
- R14: A result with a nonzero fault code has a physical address of 0 and an uncacheable flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translate request this cycle |
| req_pc | input | 64 | Fetch address |
| req_phys | input | 1 | Treat address as physical |
| req_mode | input | 2 | Current mode, 0 is kernel |
| req_sp_enable | input | 1 | Superpage window enable |
| req_asn | input | 8 | Current address space number |
| ptbase | input | 64 | Page table base for the formatted fault address |
| tlb_vpn | output | 30 | Lookup page number (address bits 42:13) |
| tlb_asn | output | 8 | Lookup address space number |
| tlb_hit | input | 1 | Lookup hit, same cycle |
| tlb_pfn | input | 31 | Page frame of the hit entry |
| tlb_xmask | input | 4 | Execute permission, one bit per mode |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| fault_tag | output | 64 | Fetch address of the last recorded fault |
| fault_vaform | output | 64 | Formatted table pointer of the last recorded fault |

## Verification
The assertions assume that the lookup port responds in the same cycle, based only on `tlb_vpn` and `tlb_asn`. The bench's buffer model does exactly that, with a combinational search over a few fixed entries. The assertions also assume that the request inputs are stable around each rising edge. The bench changes them only on falling edges, and it leaves `req_pc` unchanged on idle cycles, so that stored fault values can be compared against the last request. Superpage and firmware addresses are chosen so that the windows fall on canonical values, which keeps each vector on the path it is meant to test.

// File: rtl/ift_pkg.sv
package ift_pkg;
   typedef enum logic [1:0] {
      IFT_OK   = 2'd0,
      IFT_ACV  = 2'd1,
      IFT_MISS = 2'd2,
      IFT_MCHK = 2'd3
   } ift_fault_e;

   localparam int unsigned IFT_KERNEL = 0;
endpackage

// File: rtl/ift_va_check.sv
module ift_va_check #(
   parameter int unsigned VA_W   = 43,
   parameter logic [1:0]  SP_SEL = 2'b10
) (
   input  logic [63:VA_W-2] va_hi,
   output logic             canon_ok,
   output logic             sp_region
);
   localparam int unsigned EXT_W = 65 - VA_W;

   // bits above the implemented width must copy the top implemented bit
   assign canon_ok  = (va_hi[63:VA_W-1] == {EXT_W{va_hi[VA_W-1]}});
   assign sp_region = (va_hi[VA_W-1:VA_W-2] == SP_SEL);
endmodule

// File: rtl/ift_pa_build.sv
module ift_pa_build #(
   parameter int unsigned PA_W        = 44,
   parameter int unsigned PG_W        = 13,
   parameter int unsigned UC_LO       = 39,
   parameter int unsigned UC_HI       = 40,
   parameter bit          SP_SIGN_EXT = 1'b1,
   localparam int unsigned PFN_W      = PA_W - PG_W
) (
   input  logic [PA_W-1:0]  va,
   input  logic [PFN_W-1:0] pfn,
   output logic [PA_W-1:0]  fw_pa,
   output logic [PA_W-1:0]  sp_pa,
   output logic [PA_W-1:0]  tlb_pa
);
   localparam logic [PA_W-1:0] LOW_MASK = {{(PA_W-UC_HI){1'b0}}, {UC_HI{1'b1}}};
   localparam logic [PA_W-1:0] HI_FILL  = ~LOW_MASK;

   assign fw_pa  = {va[PA_W-1:2], 2'b00};
   assign tlb_pa = {pfn, va[PG_W-1:2], 2'b00};

   generate
      if (SP_SIGN_EXT) begin : g_sx
         always_comb begin
            if (va[UC_LO] || va[UC_HI]) sp_pa = va | HI_FILL;
            else                        sp_pa = va & LOW_MASK;
         end
      end else begin : g_raw
         assign sp_pa = va;
      end
   endgenerate
endmodule

// File: rtl/ift_fault_rec.sv
module ift_fault_rec #(
   parameter int unsigned VA_W = 43,
   parameter int unsigned PG_W = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [63:0] pc,
   input  logic [63:0] base,
   output logic [63:0] tag_q,
   output logic [63:0] form_q
);
   localparam int unsigned VPN_W = VA_W - PG_W;

   logic [63:0] vpn_x8;
   assign vpn_x8 = 64'(pc[VA_W-1:PG_W]) << 3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q  <= '0;
         form_q <= '0;
      end else if (we) begin
         tag_q  <= pc;
         form_q <= base | vpn_x8;
      end
   end

   initial begin : p_elab
      if (VPN_W + 3 > 64) $error("ift_fault_rec: page number too wide");
   end
endmodule

// File: rtl/ifetch_xlate.sv
module ifetch_xlate
   import ift_pkg::*;
#(
   parameter int unsigned VA_W        = 43,
   parameter int unsigned PA_W        = 44,
   parameter int unsigned PG_W        = 13,
   parameter int unsigned ASN_W       = 8,
   parameter int unsigned MODE_W      = 2,
   parameter int unsigned UC_LO       = 39,
   parameter int unsigned UC_HI       = 40,
   parameter bit          SP_SIGN_EXT = 1'b1,
   localparam int unsigned VPN_W      = VA_W - PG_W,
   localparam int unsigned PFN_W      = PA_W - PG_W,
   localparam int unsigned NMODE      = 1 << MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [63:0]       req_pc,
   input  logic              req_phys,
   input  logic [MODE_W-1:0] req_mode,
   input  logic              req_sp_enable,
   input  logic [ASN_W-1:0]  req_asn,
   input  logic [63:0]       ptbase,
   output logic [VPN_W-1:0]  tlb_vpn,
   output logic [ASN_W-1:0]  tlb_asn,
   input  logic              tlb_hit,
   input  logic [PFN_W-1:0]  tlb_pfn,
   input  logic [NMODE-1:0]  tlb_xmask,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_uncached,
   output logic [1:0]        rsp_fault,
   output logic [63:0]       fault_tag,
   output logic [63:0]       fault_vaform
);
   initial begin : p_elab
      if (VA_W >= 64 || VA_W < PG_W + 3) $error("ifetch_xlate: bad VA_W");
      if (PA_W >= 64 || PA_W <= UC_HI)   $error("ifetch_xlate: bad PA_W");
      if (UC_LO >= UC_HI)                $error("ifetch_xlate: uncached bits out of order");
   end

   logic             canon_ok, sp_region;
   logic [PA_W-1:0]  fw_pa, sp_pa, tlb_pa;
   logic [PA_W-1:0]  nxt_pa;
   ift_fault_e       nxt_fault;
   logic             nxt_uc, chk_pa, rec_fault;

   assign tlb_vpn = req_pc[VA_W-1:PG_W];
   assign tlb_asn = req_asn;

   ift_va_check #(.VA_W(VA_W), .SP_SEL(2'b10)) u_va_check (
      .va_hi     (req_pc[63:VA_W-2]),
      .canon_ok  (canon_ok),
      .sp_region (sp_region)
   );

   ift_pa_build #(
      .PA_W(PA_W), .PG_W(PG_W), .UC_LO(UC_LO), .UC_HI(UC_HI), .SP_SIGN_EXT(SP_SIGN_EXT)
   ) u_pa_build (
      .va     (req_pc[PA_W-1:0]),
      .pfn    (tlb_pfn),
      .fw_pa  (fw_pa),
      .sp_pa  (sp_pa),
      .tlb_pa (tlb_pa)
   );

   // path priority: firmware, physical, canonical, superpage, lookup
   always_comb begin
      nxt_fault = IFT_OK;
      nxt_pa    = '0;
      chk_pa    = 1'b0;
      rec_fault = 1'b0;
      if (req_pc[0]) begin
         nxt_pa = fw_pa;
      end else if (req_phys) begin
         if (|req_pc[63:PA_W]) nxt_fault = IFT_MCHK;
         else begin
            nxt_pa = req_pc[PA_W-1:0];
            chk_pa = 1'b1;
         end
      end else if (!canon_ok) begin
         nxt_fault = IFT_ACV;
         rec_fault = 1'b1;
      end else if (req_sp_enable && sp_region) begin
         if (req_mode != MODE_W'(IFT_KERNEL)) begin
            nxt_fault = IFT_ACV;
            rec_fault = 1'b1;
         end else begin
            nxt_pa = sp_pa;
            chk_pa = 1'b1;
         end
      end else if (!tlb_hit) begin
         nxt_fault = IFT_MISS;
         rec_fault = 1'b1;
      end else if (!tlb_xmask[req_mode]) begin
         nxt_fault = IFT_ACV;
         rec_fault = 1'b1;
      end else begin
         nxt_pa = tlb_pa;
         chk_pa = 1'b1;
      end
      nxt_uc = chk_pa && (nxt_pa[UC_LO] || nxt_pa[UC_HI]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_pa       <= '0;
         rsp_uncached <= 1'b0;
         rsp_fault    <= 2'd0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_pa       <= nxt_pa;
            rsp_uncached <= nxt_uc;
            rsp_fault    <= nxt_fault;
         end
      end
   end

   ift_fault_rec #(.VA_W(VA_W), .PG_W(PG_W)) u_fault_rec (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (req_valid && rec_fault),
      .pc     (req_pc),
      .base   (ptbase),
      .tag_q  (fault_tag),
      .form_q (fault_vaform)
   );

   AST_FW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_pc[0]) |=> (rsp_fault == IFT_OK && !rsp_uncached)); // R1
   AST_MCHK_PHYS_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault == IFT_MCHK) |-> ($past(req_phys) && !$past(req_pc[0]))); // R10
   AST_UC_FROM_BITS: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_uncached) |-> (rsp_pa[UC_LO] || rsp_pa[UC_HI])); // R11
   AST_TAG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && (rsp_fault == IFT_ACV || rsp_fault == IFT_MISS)) |-> (fault_tag == $past(req_pc))); // R12
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> ($stable(fault_tag) && $stable(fault_vaform))); // R13
   AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault != IFT_OK) |-> (rsp_pa == '0 && !rsp_uncached)); // R14
endmodule

// File: tb/ifetch_xlate_bench.sv
module ifetch_xlate_bench;
   typedef struct {
      logic [43:0] pa;
      logic        uc;
      logic [1:0]  flt;
      logic [63:0] tag;
      logic [63:0] form;
      string       rq;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_pc = '0;
   logic        req_phys = 1'b0;
   logic [1:0]  req_mode = '0;
   logic        req_sp_enable = 1'b0;
   logic [7:0]  req_asn = '0;
   logic [63:0] ptbase = 64'h0000_0200_0000_0000;
   logic [29:0] tlb_vpn;
   logic [7:0]  tlb_asn;
   logic        tlb_hit;
   logic [30:0] tlb_pfn;
   logic [3:0]  tlb_xmask;
   logic        rsp_valid, rsp_uncached;
   logic [43:0] rsp_pa;
   logic [1:0]  rsp_fault;
   logic [63:0] fault_tag, fault_vaform;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;
   exp_t sb[$];
   logic [63:0] exp_tag = '0;
   logic [63:0] exp_form = '0;

   // small translation buffer model
   logic [29:0] tv [3];
   logic [7:0]  ta [3];
   logic        tg [3];
   logic [30:0] tp [3];
   logic [3:0]  tx [3];

   always #5 clk = ~clk;

   ifetch_xlate u_ifetch_xlate (
      .clk, .rst_n, .req_valid, .req_pc, .req_phys, .req_mode, .req_sp_enable,
      .req_asn, .ptbase, .tlb_vpn, .tlb_asn, .tlb_hit, .tlb_pfn, .tlb_xmask,
      .rsp_valid, .rsp_pa, .rsp_uncached, .rsp_fault, .fault_tag, .fault_vaform
   );

   always_comb begin
      tlb_hit = 1'b0; tlb_pfn = '0; tlb_xmask = '0;
      for (int i = 0; i < 3; i++) begin
         if (!tlb_hit && tv[i] == tlb_vpn && (tg[i] || ta[i] == tlb_asn)) begin
            tlb_hit = 1'b1; tlb_pfn = tp[i]; tlb_xmask = tx[i];
         end
      end
   end

   function automatic void ref_model(input logic [63:0] pc, input logic phys, input logic [1:0] mode,
                                     input logic spen, input logic [7:0] asn,
                                     output logic [43:0] pa, output logic uc,
                                     output logic [1:0] flt, output logic rec);
      logic [43:0] p;
      logic found;
      int k;
      pa = '0; uc = 1'b0; flt = 2'd0; rec = 1'b0; found = 1'b0; k = 0;
      if (pc[0]) begin
         pa = pc[43:0] & ~44'h3;
         return;
      end
      if (phys) begin
         if (pc[63:44] != 20'd0) flt = 2'd3;
         else begin pa = pc[43:0]; uc = pc[39] | pc[40]; end
         return;
      end
      if (pc[63:42] != {22{pc[42]}}) begin flt = 2'd1; rec = 1'b1; return; end
      if (spen && pc[42:41] == 2'b10) begin
         if (mode != 2'd0) begin flt = 2'd1; rec = 1'b1; return; end
         p = pc[43:0];
         p[43:40] = (p[39] | p[40]) ? 4'hF : 4'h0;
         pa = p; uc = p[39] | p[40];
         return;
      end
      for (int i = 2; i >= 0; i--)
         if (tv[i] == pc[42:13] && (tg[i] || ta[i] == asn)) begin found = 1'b1; k = i; end
      if (!found) begin flt = 2'd2; rec = 1'b1; return; end
      if (!tx[k][mode]) begin flt = 2'd1; rec = 1'b1; return; end
      pa = {tp[k], pc[12:2], 2'b00};
      uc = pa[39] | pa[40];
   endfunction

   task automatic apply(input logic [63:0] pc, input logic phys, input logic [1:0] mode,
                        input logic spen, input logic [7:0] asn, input string rq);
      exp_t e;
      logic rec;
      @(negedge clk);
      req_valid = 1'b1; req_pc = pc; req_phys = phys; req_mode = mode;
      req_sp_enable = spen; req_asn = asn;
      ref_model(pc, phys, mode, spen, asn, e.pa, e.uc, e.flt, rec);
      if (rec) begin
         exp_tag  = pc;
         exp_form = ptbase | (64'(pc[42:13]) << 3);
      end
      e.tag = exp_tag; e.form = exp_form; e.rq = rq;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // monitor: compare each response against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_vec++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R13 unexpected response: valid=%0b expected no response", rsp_valid);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_pa !== e.pa || rsp_uncached !== e.uc || rsp_fault !== e.flt ||
                fault_tag !== e.tag || fault_vaform !== e.form) begin
               n_bad++;
               $display("FAIL %s pa=%h uc=%0b flt=%0d tag=%h form=%h expected pa=%h uc=%0b flt=%0d tag=%h form=%h",
                        e.rq, rsp_pa, rsp_uncached, rsp_fault, fault_tag, fault_vaform,
                        e.pa, e.uc, e.flt, e.tag, e.form);
            end
         end
      end
   end

   initial begin : watchdog
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: run did not complete, expected completion");
         finish_run();
      end
   end

   initial begin : stim
      tv[0] = 30'h0000_0012; ta[0] = 8'd5; tg[0] = 1'b0; tp[0] = 31'h0123_4567; tx[0] = 4'b0001;
      tv[1] = 30'h0003_ABCD; ta[1] = 8'd0; tg[1] = 1'b1; tp[1] = 31'h0400_0001; tx[1] = 4'b1111;
      tv[2] = 30'h2000_0002; ta[2] = 8'd0; tg[2] = 1'b1; tp[2] = 31'h0000_0055; tx[2] = 4'b1111;

      repeat (3) @(negedge clk);
      n_vec++;
      if (rsp_valid !== 1'b0 || rsp_pa !== '0 || rsp_fault !== 2'd0 || fault_tag !== '0) begin
         n_bad++;
         $display("FAIL R13 reset state valid=%0b pa=%h flt=%0d tag=%h expected all zero",
                  rsp_valid, rsp_pa, rsp_fault, fault_tag);
      end
      rst_n = 1'b1;
      idle(2);

      apply(64'hABCD_0000_1234_5679, 1'b1, 2'd3, 1'b1, 8'd9, "R1");
      apply(64'hFFFF_FD00_0000_0003, 1'b0, 2'd2, 1'b1, 8'd9, "R1");
      apply(64'h0000_0123_4567_89A8, 1'b1, 2'd3, 1'b0, 8'd5, "R2 R11");
      apply(64'h0000_0000_0002_41A4, 1'b1, 2'd1, 1'b0, 8'd5, "R2");
      apply(64'h0010_0000_0000_0000, 1'b1, 2'd0, 1'b0, 8'd5, "R10 R14");
      apply(64'h0000_0800_0000_0000, 1'b0, 2'd0, 1'b0, 8'd5, "R3 R12");
      idle(2);
      apply(64'hFFFF_FD00_0000_1234, 1'b0, 2'd0, 1'b1, 8'd5, "R4 R11");
      apply(64'hFFFF_FC00_0001_2344, 1'b0, 2'd0, 1'b1, 8'd5, "R4");
      apply(64'hFFFF_FC80_0000_0010, 1'b0, 2'd0, 1'b1, 8'd5, "R4 R11");
      apply(64'hFFFF_FC00_0000_2000, 1'b0, 2'd2, 1'b1, 8'd5, "R5 R12");
      apply(64'hFFFF_FC00_0000_4000, 1'b0, 2'd3, 1'b0, 8'd1, "R6 R8");
      apply(64'h0000_0000_0009_0000, 1'b0, 2'd0, 1'b0, 8'd5, "R7 R12 R14");
      apply(64'h0000_0000_0002_41A6, 1'b0, 2'd0, 1'b0, 8'd6, "R7");
      apply(64'h0000_0000_0002_41A6, 1'b0, 2'd0, 1'b0, 8'd5, "R8");
      apply(64'h0000_0000_0002_41A6, 1'b0, 2'd1, 1'b0, 8'd5, "R9 R12");
      apply(64'h0000_0000_7579_A010, 1'b0, 2'd2, 1'b0, 8'd3, "R8 R11");
      apply(64'h0000_0000_0002_41A6, 1'b1, 2'd1, 1'b0, 8'd77, "R2");
      idle(4);

      n_vec++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R13 missing responses: %0d pending expected 0", sb.size());
      end
      n_vec++;
      if (fault_tag !== exp_tag || fault_vaform !== exp_form) begin
         n_bad++;
         $display("FAIL R13 idle fault regs tag=%h form=%h expected tag=%h form=%h",
                  fault_tag, fault_vaform, exp_tag, exp_form);
      end
      done = 1'b1;
      finish_run();
   end
endmodule